// File: doc/BRIEF.md
# Tiled Matrix-Vector Multiplier

This block computes one tile of a neural-network layer: every row of a weight tile multiplied by a node-value vector, giving one 32-bit partial sum per row. A downstream accumulator collects these sums across several tiles to build a full layer, so the same arithmetic is used again on each pass. Weights arrive one value per beat on a streaming input, in row-major order (row 0 columns 0..C-1, then row 1, and so on). Each row is written into one of 32 memory banks chosen by its row index, so a single cycle reads one weight from every bank. That covers 32 rows at one column position. The node values for the tile arrive on a second stream.

Software first writes the tile shape (rows R and columns C) with a configuration strobe, then loads weights and nodes, then pulses start. The engine steps through row groups of 32 and, within each group, through columns, issuing one column per clock. Two operand register sets take turns: while one is being filled from the banks, the other feeds the multipliers. When the tile is finished, the per-row sums leave on a valid/ready stream. Each beat carries the row index, and the final beat of the tile is flagged. Weights and nodes stay in place after a tile, so a new node vector can be run against the same weights.

Top module: `tile_mv_engine`

## Requirements
- R1: The weight beat for row r, column c is written into bank r mod 32 at word (r div 32)*MAX_COLS + c. Rows r and r+32 therefore never overwrite each other.
- R2: Each compute cycle reads one weight from every bank, so one issued column advances up to 32 rows at once. A tile takes G*C issue cycles, where G = ceil(R/32).
- R3: Successive compute cycles take their operands from alternating register sets.
- R4: The first result beat is offered exactly G*C+1 clock cycles after the cycle in which start is sampled. No idle cycle occurs between issued columns.
- R5: Results are sent as exactly R beats, rows 0 to R-1 in ascending order. A beat transfers on a clock edge where out_valid and out_ready are both high. While out_ready is low, the beat and its row index hold steady.
- R6: out_last is high only on the beat for row R-1. After that beat transfers, out_valid stays low and busy falls.
- R7: Each partial sum equals the sum over c of w[r][c]*x[c]. The operands are 16-bit two's complement, and the sum wraps modulo 2^32 with no saturation.
- R8: While busy, w_ready and x_ready are low and load beats are ignored. Stored weights and nodes survive a tile, so a later start with only new nodes uses the old weights.
- R9: cfg_wr, when idle, sets R (1..MAX_ROWS) and C (1..MAX_COLS) and restarts both load counters. Node beats fill x[0..C-1] in order, then wrap to x[0].
- R10: After reset, out_valid and busy are low, and w_ready and x_ready are high.
- R11: A start pulse while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Latch tile shape, restart load counters (idle only) |
| cfg_rows | input | 7 | Rows per tile, 1..MAX_ROWS |
| cfg_cols | input | 5 | Columns per tile, 1..MAX_COLS |
| w_valid | input | 1 | Weight beat valid |
| w_ready | output | 1 | Weight beat accepted (high when idle) |
| w_data | input | 16 | Signed weight value |
| x_valid | input | 1 | Node beat valid |
| x_ready | output | 1 | Node beat accepted (high when idle) |
| x_data | input | 16 | Signed node value |
| start | input | 1 | Begin computing the configured tile |
| busy | output | 1 | Tile in progress (compute or result drain) |
| out_valid | output | 1 | Result beat valid |
| out_ready | input | 1 | Downstream accepts result beat |
| out_psum | output | 32 | Signed partial sum of one row |
| out_row | output | 6 | Row index of the beat |
| out_last | output | 1 | Final beat of the tile |

## Verification
A wrong bank mapping or address would first show as wrong sums for rows 32 and above, or for rows sharing a bank with them. This appears within the drain of the first tile that has more than 32 rows. A ping-pong select that pairs the wrong operand set, or a slipped column counter, corrupts every sum at once. A miscounted issue loop moves the first out_valid off the exact G*C+1 cycle count. Faults in the drain counter or the last flag show as a missing, repeated or misordered row index, or as extra beats after the flagged one.

// File: rtl/tmv_pkg.sv
package tmv_pkg;
  localparam int OPW  = 16;
  localparam int ACCW = 32;

  typedef logic signed [OPW-1:0]  opnd_t;
  typedef logic signed [ACCW-1:0] psum_t;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_FLUSH, ST_DRAIN} eng_state_t;

  // One multiply-accumulate step; 'first' restarts the row sum.
  function automatic psum_t mac_step(psum_t acc, opnd_t w, opnd_t x, logic first);
    psum_t p;
    p = psum_t'(w) * psum_t'(x);
    return first ? p : acc + p;
  endfunction
endpackage

// File: rtl/tmv_bank.sv
module tmv_bank
  import tmv_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  opnd_t         wdata,
  input  logic [AW-1:0] raddr,
  output opnd_t         rdata
);
  opnd_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/tmv_loader.sv
module tmv_loader #(
  parameter int MAX_ROWS = 64,
  parameter int MAX_COLS = 16,
  localparam int RCW = $clog2(MAX_ROWS + 1),
  localparam int CCW = $clog2(MAX_COLS + 1),
  localparam int RIW = $clog2(MAX_ROWS),
  localparam int CIW = $clog2(MAX_COLS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic [RCW-1:0] rows,
  input  logic [CCW-1:0] cols,
  input  logic           w_fire,
  input  logic           x_fire,
  output logic [RIW-1:0] w_row,
  output logic [CIW-1:0] w_col,
  output logic [CIW-1:0] x_idx
);
  logic w_col_end, w_row_end, x_end;
  assign w_col_end = (int'(w_col) == int'(cols) - 1);
  assign w_row_end = (int'(w_row) == int'(rows) - 1);
  assign x_end     = (int'(x_idx) == int'(cols) - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w_row <= '0;
      w_col <= '0;
      x_idx <= '0;
    end else if (clear) begin
      w_row <= '0;
      w_col <= '0;
      x_idx <= '0;
    end else begin
      if (w_fire) begin
        if (w_col_end) begin
          w_col <= '0;
          w_row <= w_row_end ? '0 : w_row + 1'b1;
        end else begin
          w_col <= w_col + 1'b1;
        end
      end
      if (x_fire) x_idx <= x_end ? '0 : x_idx + 1'b1;
    end
  end
endmodule

// File: rtl/tile_mv_engine.sv
module tile_mv_engine
  import tmv_pkg::*;
#(
  parameter int BANKS    = 32,
  parameter int MAX_ROWS = 64,
  parameter int MAX_COLS = 16,
  localparam int RCW  = $clog2(MAX_ROWS + 1),
  localparam int CCW  = $clog2(MAX_COLS + 1),
  localparam int RIW  = $clog2(MAX_ROWS),
  localparam int CIW  = $clog2(MAX_COLS),
  localparam int GMAX = (MAX_ROWS + BANKS - 1) / BANKS,
  localparam int GW   = (GMAX > 1) ? $clog2(GMAX) : 1,
  localparam int DB   = GMAX * MAX_COLS,
  localparam int ABW  = (DB > 1) ? $clog2(DB) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [RCW-1:0]  cfg_rows,
  input  logic [CCW-1:0]  cfg_cols,
  input  logic            w_valid,
  output logic            w_ready,
  input  logic [OPW-1:0]  w_data,
  input  logic            x_valid,
  output logic            x_ready,
  input  logic [OPW-1:0]  x_data,
  input  logic            start,
  output logic            busy,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [ACCW-1:0] out_psum,
  output logic [RIW-1:0]  out_row,
  output logic            out_last
);
  eng_state_t     state;
  logic [RCW-1:0] rows_q;
  logic [CCW-1:0] cols_q;
  logic [GW-1:0]  f_grp, ngrp_m1;
  logic [CIW-1:0] f_col;
  logic [RIW-1:0] ocnt;

  // Named internal events
  logic w_fire, x_fire, cfg_take, fetch_fire, fetch_col_end, fetch_end, out_fire;
  logic [BANKS-1:0] bank_we;

  logic [RIW-1:0] w_row;
  logic [CIW-1:0] w_col, x_idx;
  logic [ABW-1:0] bank_waddr, bank_raddr;
  opnd_t          bank_rd [BANKS];
  opnd_t          xbuf [MAX_COLS];

  // Ping-pong operand sets and MAC stage tags
  opnd_t          opw [2][BANKS];
  opnd_t          opx [2];
  logic           psel, mac_v, mac_set, mac_first, mac_last;
  logic [GW-1:0]  mac_grp;
  psum_t          acc [MAX_ROWS];

  assign busy     = (state != ST_IDLE);
  assign w_ready  = !busy;
  assign x_ready  = !busy;
  assign w_fire   = w_valid && w_ready;
  assign x_fire   = x_valid && x_ready;
  assign cfg_take = cfg_wr && !busy;

  assign ngrp_m1       = GW'((int'(rows_q) + BANKS - 1) / BANKS - 1);
  assign fetch_fire    = (state == ST_RUN);
  assign fetch_col_end = (int'(f_col) == int'(cols_q) - 1);
  assign fetch_end     = fetch_fire && fetch_col_end && (f_grp == ngrp_m1);

  assign out_valid = (state == ST_DRAIN);
  assign out_row   = ocnt;
  assign out_psum  = acc[ocnt];
  assign out_last  = out_valid && (int'(ocnt) == int'(rows_q) - 1);
  assign out_fire  = out_valid && out_ready;

  tmv_loader #(.MAX_ROWS(MAX_ROWS), .MAX_COLS(MAX_COLS)) u_loader (
    .clk(clk), .rst_n(rst_n), .clear(cfg_take), .rows(rows_q), .cols(cols_q),
    .w_fire(w_fire), .x_fire(x_fire), .w_row(w_row), .w_col(w_col), .x_idx(x_idx)
  );

  // Row r goes to bank r mod BANKS, word (r div BANKS)*MAX_COLS + c
  assign bank_waddr = ABW'((int'(w_row) / BANKS) * MAX_COLS + int'(w_col));
  assign bank_raddr = ABW'(int'(f_grp) * MAX_COLS + int'(f_col));

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    assign bank_we[b] = w_fire && ((int'(w_row) % BANKS) == b);
    tmv_bank #(.DEPTH(DB)) u_bank (
      .clk(clk), .we(bank_we[b]), .waddr(bank_waddr), .wdata(opnd_t'(w_data)),
      .raddr(bank_raddr), .rdata(bank_rd[b])
    );
  end

  always_ff @(posedge clk) begin
    if (x_fire) xbuf[x_idx] <= opnd_t'(x_data);
  end

  // Control sequencer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      rows_q <= RCW'(MAX_ROWS);
      cols_q <= CCW'(MAX_COLS);
      f_grp  <= '0;
      f_col  <= '0;
      ocnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (cfg_take) begin
            rows_q <= cfg_rows;
            cols_q <= cfg_cols;
          end
          if (start) begin
            state <= ST_RUN;
            f_grp <= '0;
            f_col <= '0;
            ocnt  <= '0;
          end
        end
        ST_RUN: begin
          if (fetch_end) begin
            state <= ST_FLUSH;
          end else if (fetch_col_end) begin
            f_col <= '0;
            f_grp <= f_grp + 1'b1;
          end else begin
            f_col <= f_col + 1'b1;
          end
        end
        ST_FLUSH: if (mac_v && mac_last) state <= ST_DRAIN;
        ST_DRAIN: begin
          if (out_fire) begin
            if (out_last) state <= ST_IDLE;
            else          ocnt  <= ocnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Operand fetch into the set selected by psel; MAC uses the other one
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psel      <= 1'b0;
      mac_v     <= 1'b0;
      mac_set   <= 1'b0;
      mac_first <= 1'b0;
      mac_last  <= 1'b0;
      mac_grp   <= '0;
      for (int s = 0; s < 2; s++) begin
        opx[s] <= '0;
        for (int b = 0; b < BANKS; b++) opw[s][b] <= '0;
      end
    end else begin
      mac_v <= fetch_fire;
      if (fetch_fire) begin
        for (int b = 0; b < BANKS; b++) opw[psel][b] <= bank_rd[b];
        opx[psel] <= xbuf[f_col];
        psel      <= ~psel;
        mac_set   <= psel;
        mac_grp   <= f_grp;
        mac_first <= (f_col == '0);
        mac_last  <= fetch_end;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < MAX_ROWS; r++) acc[r] <= '0;
    end else if (mac_v) begin
      for (int r = 0; r < MAX_ROWS; r++)
        if (int'(mac_grp) == r / BANKS)
          acc[r] <= mac_step(acc[r], opw[mac_set][r % BANKS], opx[mac_set], mac_first);
    end
  end

  // Assertions
  AST_BANK_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_we != '0) |-> (w_fire && $countones(bank_we) == 1)); // R1
  AST_SET_ALTERNATE: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_v && $past(mac_v)) |-> (mac_set != $past(mac_set))); // R3
  AST_NO_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mac_v && !mac_last) |=> mac_v); // R4
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_psum) && $stable(out_row))); // R5
  AST_LAST_END: assert property (@(posedge clk) disable iff (!rst_n)
    (out_fire && out_last) |=> (!out_valid && !busy)); // R6
  AST_LOAD_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!w_ready && !x_ready)); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && state == ST_DRAIN && !out_fire) |=> (state == ST_DRAIN)); // R11
endmodule

// File: tb/tb_tile_mv_engine.sv
module tb_tile_mv_engine;
  localparam int MR = 64;
  localparam int MC = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [6:0]  cfg_rows = '0;
  logic [4:0]  cfg_cols = '0;
  logic        w_valid = 1'b0, x_valid = 1'b0, start = 1'b0, out_ready = 1'b0;
  logic [15:0] w_data = '0, x_data = '0;
  logic        w_ready, x_ready, busy, out_valid, out_last;
  logic [31:0] out_psum;
  logic [5:0]  out_row;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int W [MR][MC];
  int X [MC];

  always #10 clk = ~clk;

  tile_mv_engine dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rows(cfg_rows), .cfg_cols(cfg_cols),
    .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
    .x_valid(x_valid), .x_ready(x_ready), .x_data(x_data),
    .start(start), .busy(busy), .out_valid(out_valid), .out_ready(out_ready),
    .out_psum(out_psum), .out_row(out_row), .out_last(out_last)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_cfg(input int rows, input int cols);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_rows = 7'(rows); cfg_cols = 5'(cols);
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // kind 0: pattern, kind 1: all most-negative
  task automatic load_w(input int rows, input int cols, input int kind, input int seed);
    for (int r = 0; r < rows; r++)
      for (int c = 0; c < cols; c++) begin
        W[r][c] = (kind == 1) ? -32768 : ((r * 37 + c * 13 + seed) % 401) - 200;
        if (kind == 0 && r == 5 && c == 0) W[r][c] = 32767;
        @(negedge clk);
        w_valid = 1'b1; w_data = 16'(W[r][c]);
        @(posedge clk);
      end
    @(negedge clk);
    w_valid = 1'b0;
  endtask

  task automatic load_x(input int cols, input int kind, input int seed);
    for (int c = 0; c < cols; c++) begin
      X[c] = (kind == 1) ? -32768 : ((c * 29 + seed) % 251) - 125;
      @(negedge clk);
      x_valid = 1'b1; x_data = 16'(X[c]);
      @(posedge clk);
    end
    @(negedge clk);
    x_valid = 1'b0;
  endtask

  task automatic run_tile(input int rows, input int cols, input int rseed, input bit poke);
    logic [31:0] expv [MR];
    int n, beats, cyc, g;
    bit prev_stall;
    logic [31:0] prev_d;
    logic [5:0] prev_r;
    for (int r = 0; r < rows; r++) begin
      longint s = 0;
      for (int c = 0; c < cols; c++) s += longint'(W[r][c]) * longint'(X[c]);
      expv[r] = s[31:0];
    end
    g = (rows + 31) / 32;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    n = 0;
    while (!out_valid && n < 4000) begin
      @(posedge clk); n++; @(negedge clk);
    end
    chk(n == g * cols + 1, "R4 first-beat latency", n, g * cols + 1);
    beats = 0; cyc = 0; prev_stall = 0; prev_d = '0; prev_r = '0;
    while (beats < rows && cyc < 4000) begin
      if (prev_stall) begin
        chk(out_valid && out_psum == prev_d && out_row == prev_r, "R5 hold under stall",
            out_psum, prev_d);
      end
      if (poke && cyc == 1) begin
        start = 1'b1; w_valid = 1'b1; x_valid = 1'b1;
        chk(w_ready == 1'b0 && x_ready == 1'b0, "R8 loads refused while busy", w_ready, 0);
      end else begin
        start = 1'b0; w_valid = 1'b0; x_valid = 1'b0;
      end
      out_ready = ((cyc * 5 + rseed) % 3) != 0;
      if (out_valid) begin
        chk(out_row == 6'(beats), "R5 row order", out_row, beats);
        chk(out_psum == expv[beats], "R7 partial sum", $signed(out_psum), $signed(expv[beats]));
        chk(out_last == (beats == rows - 1), "R6 last flag", out_last, beats == rows - 1);
      end
      prev_stall = out_valid && !out_ready;
      prev_d = out_psum; prev_r = out_row;
      @(posedge clk);
      if (out_valid && out_ready) beats++;
      cyc++;
      @(negedge clk);
    end
    start = 1'b0; w_valid = 1'b0; x_valid = 1'b0; out_ready = 1'b1;
    chk(beats == rows, "R5 beat count", beats, rows);
    repeat (3) @(negedge clk);
    chk(!out_valid && !busy, "R6 R11 idle after final beat", out_valid, 0);
    out_ready = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!out_valid && !busy && w_ready && x_ready, "R10 reset state", {out_valid, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !busy && w_ready && x_ready, "R10 idle after reset", busy, 0);

    do_cfg(5, 3);  load_w(5, 3, 0, 1);   load_x(3, 0, 4);  run_tile(5, 3, 0, 0);
    do_cfg(1, 1);  load_w(1, 1, 0, 9);   load_x(1, 0, 2);  run_tile(1, 1, 1, 0);
    do_cfg(40, 7); load_w(40, 7, 0, 3);  load_x(7, 0, 11); run_tile(40, 7, 2, 1);
    // R8 weight reuse: new nodes only
    load_x(7, 0, 77); run_tile(40, 7, 1, 0);
    // R9 node index wraps: 10 beats into 7 columns leaves x[0..2] rewritten
    begin
      for (int c = 0; c < 10; c++) begin
        int v = (c * 53 + 5) % 97 - 48;
        X[c % 7] = v;
        @(negedge clk); x_valid = 1'b1; x_data = 16'(v); @(posedge clk);
      end
      @(negedge clk); x_valid = 1'b0;
      // realign counter by completing the wrap
      for (int c = 3; c < 7; c++) begin
        @(negedge clk); x_valid = 1'b1; x_data = 16'(X[c]); @(posedge clk);
      end
      @(negedge clk); x_valid = 1'b0;
    end
    run_tile(40, 7, 0, 0);
    do_cfg(64, 16); load_w(64, 16, 0, 7); load_x(16, 0, 19); run_tile(64, 16, 2, 1);
    // R7 wrap: 16 * 2^30 = 2^34 wraps to 0
    do_cfg(33, 16); load_w(33, 16, 1, 0); load_x(16, 1, 0); run_tile(33, 16, 1, 0);
    do_cfg(32, 16); load_w(32, 16, 0, 5); load_x(16, 0, 3);  run_tile(32, 16, 0, 0);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule